// File: doc/BRIEF.md
# Sticky Dual-Threshold Bit Detector

This block watches a serial stream of single bits, each qualified by a valid strobe. It keeps two independent tallies, one for accepted 0s and one for accepted 1s, and each tally stops rising once it reaches the threshold (two by default). The detect output goes high when both tallies have reached the threshold, whatever order the bits came in. It then stays high until a synchronous reset.

The block is a Moore machine. The output is a registered state bit and nothing else, so it changes only on clock edges. Typical uses are a sanity gate on a link that must have shown both symbol values a few times, or a simple start-of-activity qualifier.

Top module: `dual_pair_detector`

## Requirements
- R1: While reset is sampled high at a rising edge, both tallies are cleared and `bothSeen` is 0 after that edge. After reset ends, the full quota of 0s and 1s is needed again.
- R2: A bit presented with `bitValid` = 0 is ignored. It changes neither tally nor `bothSeen`.
- R3: `bothSeen` goes to 1 right after the rising edge that accepts the bit completing the second quota. It is never 1 while either tally is below the threshold (THRESH = 2).
- R4: Detection does not depend on arrival order. Any interleaving of THRESH zeros (`bitIn` = 0) and THRESH ones (`bitIn` = 1) sets `bothSeen`.
- R5: Each tally saturates at THRESH. Any number of extra bits of one value neither wraps the tally nor stands in for the other value.
- R6: Once `bothSeen` is 1, it stays 1 on every later edge until reset, whatever the input.
- R7: Reset takes priority over a valid bit sampled at the same edge, so that bit is not counted.
- R8: `bothSeen` changes only at rising clock edges. Input changes between edges have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bitValid | input | 1 | Qualifies `bitIn` for this cycle |
| bitIn | input | 1 | Serial data bit |
| bothSeen | output | 1 | Sticky detect flag |

## Verification
The hardest case to reach from the ports is a long run of one value that drives its tally into saturation, followed by a second quota that must still be counted from zero. Random stimulus seldom builds that pattern before a random reset cuts it short. The bench therefore drives it directly: fifty ones, then single zeros, checking the output after each edge. It also forces a valid bit into the same cycle as reset, and it toggles the inputs between edges to show that the output cannot move there.

// File: rtl/detpkg.sv
package detpkg;
  typedef struct packed {
    logic clear;
    logic bumpZero;
    logic bumpOne;
  } ctrlStrobe_t;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int THRESH = 2,
  localparam int W = (THRESH < 1) ? 1 : $clog2(THRESH + 1)
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         bump,
  output logic [W-1:0] cnt,
  output logic         full,
  output logic         last
);
  localparam logic [W-1:0] TOP = W'(THRESH);
  localparam logic [W-1:0] PRE = W'(THRESH - 1);

  always_ff @(posedge clk) begin
    if (clear)
      cnt <= '0;
    else if (bump && (cnt != TOP))
      cnt <= cnt + 1'b1;
  end

  assign full = (cnt == TOP);
  assign last = (cnt == PRE);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (clear)
    full |=> full); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (clear)
    (bump && !full) |=> (cnt == $past(cnt) + 1'b1)); // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk)
    clear |=> (cnt == '0)); // R1
endmodule

// File: rtl/detect_datapath.sv
module detect_datapath
  import detpkg::*;
#(
  parameter int THRESH = 2,
  localparam int W = (THRESH < 1) ? 1 : $clog2(THRESH + 1)
) (
  input  logic        clk,
  input  ctrlStrobe_t strobe,
  output logic [W-1:0] zeroCnt,
  output logic [W-1:0] oneCnt,
  output logic        zeroFull,
  output logic        oneFull,
  output logic        zeroLast,
  output logic        oneLast
);
  localparam int LANES = 2;

  logic [LANES-1:0]        laneBump;
  logic [LANES-1:0][W-1:0] laneCnt;
  logic [LANES-1:0]        laneFull;
  logic [LANES-1:0]        laneLast;

  assign laneBump[0] = strobe.bumpZero;
  assign laneBump[1] = strobe.bumpOne;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sat_counter #(.THRESH(THRESH)) cnt_i (
      .clk   (clk),
      .clear (strobe.clear),
      .bump  (laneBump[g]),
      .cnt   (laneCnt[g]),
      .full  (laneFull[g]),
      .last  (laneLast[g])
    );
  end

  assign zeroCnt  = laneCnt[0];
  assign oneCnt   = laneCnt[1];
  assign zeroFull = laneFull[0];
  assign oneFull  = laneFull[1];
  assign zeroLast = laneLast[0];
  assign oneLast  = laneLast[1];

  AST_ONE_LANE_MOVES: assert property (@(posedge clk) disable iff (strobe.clear)
    !(strobe.bumpZero && strobe.bumpOne)); // R4
endmodule

// File: rtl/detect_control.sv
module detect_control
  import detpkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        bitValid,
  input  logic        bitIn,
  input  logic        zeroFull,
  input  logic        oneFull,
  input  logic        zeroLast,
  input  logic        oneLast,
  output ctrlStrobe_t strobe,
  output logic        detect
);
  logic zeroReach;
  logic oneReach;

  always_comb begin
    strobe.clear    = rst;
    strobe.bumpZero = !rst && bitValid && !bitIn;
    strobe.bumpOne  = !rst && bitValid && bitIn;
  end

  assign zeroReach = zeroFull || (strobe.bumpZero && zeroLast);
  assign oneReach  = oneFull  || (strobe.bumpOne  && oneLast);

  always_ff @(posedge clk) begin
    if (rst)
      detect <= 1'b0;
    else if (zeroReach && oneReach)
      detect <= 1'b1;
  end

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    detect |=> detect); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !detect); // R1
  AST_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    detect |-> (zeroFull && oneFull)); // R3
endmodule

// File: rtl/dual_pair_detector.sv
module dual_pair_detector
  import detpkg::*;
#(
  parameter int THRESH = 2,
  localparam int W = (THRESH < 1) ? 1 : $clog2(THRESH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bitValid,
  input  logic bitIn,
  output logic bothSeen
);
  ctrlStrobe_t strobe;
  logic [W-1:0] zeroCnt;
  logic [W-1:0] oneCnt;
  logic zeroFull, oneFull, zeroLast, oneLast;

  detect_control ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .zeroFull (zeroFull),
    .oneFull  (oneFull),
    .zeroLast (zeroLast),
    .oneLast  (oneLast),
    .strobe   (strobe),
    .detect   (bothSeen)
  );

  detect_datapath #(.THRESH(THRESH)) dp_i (
    .clk      (clk),
    .strobe   (strobe),
    .zeroCnt  (zeroCnt),
    .oneCnt   (oneCnt),
    .zeroFull (zeroFull),
    .oneFull  (oneFull),
    .zeroLast (zeroLast),
    .oneLast  (oneLast)
  );

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bitValid |=> ($stable(zeroCnt) && $stable(oneCnt) && $stable(bothSeen))); // R2
endmodule

// File: tb/dual_pair_detector_tb_top.sv
`timescale 1ns/1ps
module dual_pair_detector_tb_top;
  localparam int THRESH = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitValid = 1'b0;
  logic bitIn = 1'b0;
  logic bothSeen;

  int nChecks = 0;
  int nFail = 0;
  int zc = 0;
  int oc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dual_pair_detector #(.THRESH(THRESH)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .bothSeen (bothSeen)
  );

  function automatic logic expDetect(input int z, input int o);
    return (z >= THRESH) && (o >= THRESH);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: bothSeen=%0b expected %0b (zeros=%0d ones=%0d) at %0t",
               tag, act, exp, zc, oc, $time);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic b, input string tag);
    @(negedge clk);
    rst = r; bitValid = v; bitIn = b;
    @(posedge clk);
    if (r) begin
      zc = 0; oc = 0;
    end else if (v) begin
      if (b) oc++; else zc++;
    end
    #1;
    check(bothSeen, expDetect(zc, oc), tag);
  endtask

  task automatic doReset();
    step(1'b1, 1'b0, 1'b0, "R1");
    step(1'b0, 1'b0, 1'b0, "R1");
  endtask

  initial begin
    void'($urandom(32'd20240917));
    // R1: reset state
    step(1'b1, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b1, 1'b1, "R1");
    step(1'b0, 1'b0, 1'b0, "R1");

    // R2: invalid bits ignored
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, i[0], "R2");
    step(1'b0, 1'b1, 1'b0, "R3");
    step(1'b0, 1'b1, 1'b0, "R3");
    step(1'b0, 1'b1, 1'b1, "R3");
    step(1'b0, 1'b0, 1'b1, "R2");
    step(1'b0, 1'b1, 1'b1, "R3");

    // R4: several orderings
    doReset();
    step(1'b0, 1'b1, 1'b1, "R4"); step(1'b0, 1'b1, 1'b0, "R4");
    step(1'b0, 1'b1, 1'b1, "R4"); step(1'b0, 1'b1, 1'b0, "R4");
    doReset();
    step(1'b0, 1'b1, 1'b1, "R4"); step(1'b0, 1'b1, 1'b1, "R4");
    step(1'b0, 1'b1, 1'b0, "R4"); step(1'b0, 1'b1, 1'b0, "R4");
    doReset();
    step(1'b0, 1'b1, 1'b0, "R4"); step(1'b0, 1'b1, 1'b1, "R4");
    step(1'b0, 1'b1, 1'b1, "R4"); step(1'b0, 1'b1, 1'b0, "R4");

    // R5: saturation of one tally
    doReset();
    for (int i = 0; i < 50; i++) step(1'b0, 1'b1, 1'b1, "R5");
    step(1'b0, 1'b1, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, 1'b0, "R5");

    // R6: sticky under any input
    for (int i = 0; i < 30; i++) step(1'b0, i[1], i[0], "R6");

    // R7: reset wins over a valid bit in the same cycle
    doReset();
    step(1'b0, 1'b1, 1'b0, "R7"); step(1'b0, 1'b1, 1'b1, "R7");
    step(1'b0, 1'b1, 1'b1, "R7");
    step(1'b1, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, "R7"); step(1'b0, 1'b1, 1'b1, "R7");
    step(1'b0, 1'b1, 1'b1, "R7");
    step(1'b0, 1'b1, 1'b0, "R7");

    // R8: mid-cycle input activity does not move the output
    doReset();
    step(1'b0, 1'b1, 1'b0, "R8"); step(1'b0, 1'b1, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b1, "R8");
    @(negedge clk);
    bitValid = 1'b1; bitIn = 1'b1;
    #0.5;
    check(bothSeen, 1'b0, "R8");
    bitIn = 1'b0;
    #0.5;
    check(bothSeen, 1'b0, "R8");
    bitIn = 1'b1;
    @(posedge clk);
    oc++;
    #1;
    check(bothSeen, expDetect(zc, oc), "R8");

    // Random mix, R3 and R4
    for (int i = 0; i < 3000; i++) begin
      logic r, v, b;
      r = ($urandom % 64) == 0;
      v = ($urandom % 4) != 0;
      b = ($urandom % 8) < (i % 7);
      step(r, v, b, "R3");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule